// File: doc/BRIEF.md
# FM Synthesizer Register Write Decoder

This block turns a stream of register writes into the stored state of a six-channel, four-operator FM synthesizer. Each write carries an 8-bit register address, a channel select and an 8-bit data byte. The block holds the timer control field and the two-bit channel-3 special mode. It also holds the key-on level of every operator, the algorithm and feedback of each channel, the committed frequency number and block of each channel, and the three supplementary frequency sets used when channel 3 runs in special mode.

A frequency write takes two steps. The high byte, which carries the block and the top three frequency bits, only goes into a per-register holding latch. The committed values change only when the low byte arrives. When an operator's effective frequency can change, the block sets that operator's bit in a pending bitmask. Three events do this: a frequency commit, a supplementary commit while special mode is active, and a change of the special mode. A downstream phase-increment calculator clears these bits by pulsing the matching acknowledge bits.

Writes use a valid/ready handshake. `wr_ready` is held high, so the block never applies back-pressure. A write is taken on every rising clock edge where `wr_valid` is high. All state updates appear one clock after the accepting edge.

Top module: `fmw_decoder`

## Requirements
- R1: After reset every output except `wr_ready` is zero.
- R2: A write to address 0x27 stores data bits 5:0 as `tmr_ctrl` and data bits 7:6 as `sp_mode`.
- R3: A write to 0x27 whose bits 7:6 differ from the current `sp_mode` sets pending bits 8, 9 and 10. A write that leaves the mode unchanged sets no pending bit.
- R4: A write to 0x28 selects channel c from data bits 2:0. Data bits 4, 5, 6 and 7 become the key-on levels of operators 4c, 4c+1, 4c+2 and 4c+3 (1 = on).
- R5: A write to 0x28 whose data bits 2:0 are 6 or 7 changes no output.
- R6: A write to 0xA4 (frequency high) only stores the byte in the selected channel's latch. No committed frequency, block or pending bit changes.
- R7: A write to 0xA0 (frequency low) for channel c commits block = latch bits 5:3 and frequency = {latch bits 2:0, data}. It also sets pending bits 4c to 4c+3.
- R8: The supplementary registers 0xAC (high) and 0xA8 (low) act like R6/R7 on their own latches for index 0 to 2. An index of 3 or more is ignored.
- R9: A supplementary commit to index i sets pending bit 8+i only while `sp_mode` is nonzero.
- R10: A write to 0xB0 for channel c stores data bits 2:0 as the algorithm and bits 5:3 as the feedback of that channel.
- R11: An acknowledge bit clears its pending bit. A set in the same cycle takes priority over the clear.
- R12: `wr_ready` is always high. A cycle with `wr_valid` low, an unknown address, or a per-channel write with channel select 6 or 7 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | Write request |
| wr_ready | output | 1 | Write accepted (held high) |
| wr_addr | input | 8 | Register address |
| wr_chan | input | 3 | Channel or supplementary index |
| wr_data | input | 8 | Write data |
| tmr_ctrl | output | 6 | Timer control field |
| sp_mode | output | 2 | Channel-3 special mode |
| key_on | output | 24 | Per-operator key-on level, operator n at bit n |
| chan_fnum | output | 66 | Committed frequency, channel c at bits 11c+10:11c |
| chan_block | output | 18 | Committed block, channel c at bits 3c+2:3c |
| sup_fnum | output | 33 | Supplementary frequency, index i at bits 11i+10:11i |
| sup_block | output | 9 | Supplementary block, index i at bits 3i+2:3i |
| alg | output | 18 | Algorithm, channel c at bits 3c+2:3c |
| fb | output | 18 | Feedback, channel c at bits 3c+2:3c |
| recalc_pend | output | 24 | Pending recompute mask, operator n at bit n |
| recalc_ack | input | 24 | Recompute acknowledge, operator n at bit n |

## Verification
The bench pairs high and low frequency writes, including high writes that are never followed by a low write. A decoder that commits on the high byte would show the new frequency one write too early. The bench rewrites the timer register with both the same mode and a different mode. A design that compares the whole byte, or ignores the comparison, raises spurious or missing recomputes for operators 8 to 10. Key writes to channels 6 and 7, and supplementary index 3, would corrupt a neighbouring operator or register if the range checks were missing. Acknowledges that land in the same cycle as a new request expose a queue that lets the clear win.

// File: rtl/fmw_pkg.sv
package fmw_pkg;
  localparam logic [7:0] A_TMR = 8'h27;
  localparam logic [7:0] A_KEY = 8'h28;
  localparam logic [7:0] A_FLO = 8'hA0;
  localparam logic [7:0] A_FHI = 8'hA4;
  localparam logic [7:0] A_SLO = 8'hA8;
  localparam logic [7:0] A_SHI = 8'hAC;
  localparam logic [7:0] A_ALG = 8'hB0;
  localparam int FNUM_W = 11;
  localparam int BLK_W  = 3;
endpackage

// File: rtl/fmw_freq_bank.sv
module fmw_freq_bank #(
  parameter int N  = 6,
  parameter int IW = 3
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           hi_we,
  input  logic                           lo_we,
  input  logic [IW-1:0]                  idx,
  input  logic [7:0]                     data,
  output logic [N*fmw_pkg::FNUM_W-1:0]   fnum_o,
  output logic [N*fmw_pkg::BLK_W-1:0]    blk_o,
  output logic [N-1:0]                   commit_o
);
  import fmw_pkg::*;

  for (genvar gi = 0; gi < N; gi++) begin : g_slot
    logic [7:0] hold_q;
    assign commit_o[gi] = lo_we && (idx == IW'(gi));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        hold_q                          <= '0;
        fnum_o[gi*FNUM_W +: FNUM_W]     <= '0;
        blk_o[gi*BLK_W +: BLK_W]        <= '0;
      end else begin
        if (hi_we && (idx == IW'(gi)))
          hold_q <= data;
        if (commit_o[gi]) begin
          blk_o[gi*BLK_W +: BLK_W]      <= hold_q[5:3];
          fnum_o[gi*FNUM_W +: FNUM_W]   <= {hold_q[2:0], data};
        end
      end
    end
  end
endmodule

// File: rtl/fmw_recalc_q.sv
module fmw_recalc_q #(
  parameter int N = 24
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] ack_i,
  output logic [N-1:0] pend_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_o <= '0;
    else        pend_o <= (pend_o & ~ack_i) | set_i;
  end
endmodule

// File: rtl/fmw_decoder.sv
module fmw_decoder #(
  parameter  int NCH  = 6,
  parameter  int OPS  = 4,
  parameter  int SUP  = 3,
  parameter  int SPC  = 2,
  parameter  int CH_W = 3,
  localparam int NOPS = NCH * OPS
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr_valid,
  output logic                          wr_ready,
  input  logic [7:0]                    wr_addr,
  input  logic [CH_W-1:0]               wr_chan,
  input  logic [7:0]                    wr_data,
  output logic [5:0]                    tmr_ctrl,
  output logic [1:0]                    sp_mode,
  output logic [NOPS-1:0]               key_on,
  output logic [NCH*fmw_pkg::FNUM_W-1:0] chan_fnum,
  output logic [NCH*fmw_pkg::BLK_W-1:0]  chan_block,
  output logic [SUP*fmw_pkg::FNUM_W-1:0] sup_fnum,
  output logic [SUP*fmw_pkg::BLK_W-1:0]  sup_block,
  output logic [NCH*3-1:0]              alg,
  output logic [NCH*3-1:0]              fb,
  output logic [NOPS-1:0]               recalc_pend,
  input  logic [NOPS-1:0]               recalc_ack
);
  import fmw_pkg::*;

  localparam int SUP_BASE = SPC * OPS;

  logic            acc;
  logic            mode_chg;
  logic [NCH-1:0]  ch_commit;
  logic [SUP-1:0]  sup_commit;
  logic [NOPS-1:0] pend_set;
  logic [2:0]      key_ch;

  assign wr_ready = 1'b1;
  assign acc      = wr_valid && wr_ready;
  assign mode_chg = acc && (wr_addr == A_TMR) && (wr_data[7:6] != sp_mode);
  assign key_ch   = wr_data[2:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tmr_ctrl <= '0;
      sp_mode  <= '0;
    end else if (acc && (wr_addr == A_TMR)) begin
      tmr_ctrl <= wr_data[5:0];
      sp_mode  <= wr_data[7:6];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      key_on <= '0;
    end else if (acc && (wr_addr == A_KEY) && (int'(key_ch) < NCH)) begin
      for (int o = 0; o < OPS; o++)
        key_on[int'(key_ch) * OPS + o] <= wr_data[4 + o];
    end
  end

  for (genvar gc = 0; gc < NCH; gc++) begin : g_alg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        alg[gc*3 +: 3] <= '0;
        fb[gc*3 +: 3]  <= '0;
      end else if (acc && (wr_addr == A_ALG) && (wr_chan == CH_W'(gc))) begin
        alg[gc*3 +: 3] <= wr_data[2:0];
        fb[gc*3 +: 3]  <= wr_data[5:3];
      end
    end
  end

  fmw_freq_bank #(.N(NCH), .IW(CH_W)) u_chan_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .hi_we    (acc && (wr_addr == A_FHI)),
    .lo_we    (acc && (wr_addr == A_FLO)),
    .idx      (wr_chan),
    .data     (wr_data),
    .fnum_o   (chan_fnum),
    .blk_o    (chan_block),
    .commit_o (ch_commit)
  );

  fmw_freq_bank #(.N(SUP), .IW(CH_W)) u_sup_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .hi_we    (acc && (wr_addr == A_SHI)),
    .lo_we    (acc && (wr_addr == A_SLO)),
    .idx      (wr_chan),
    .data     (wr_data),
    .fnum_o   (sup_fnum),
    .blk_o    (sup_block),
    .commit_o (sup_commit)
  );

  always_comb begin
    pend_set = '0;
    for (int c = 0; c < NCH; c++)
      if (ch_commit[c]) pend_set[c*OPS +: OPS] = '1;
    for (int s = 0; s < SUP; s++)
      if ((sup_commit[s] && (sp_mode != 2'd0)) || mode_chg)
        pend_set[SUP_BASE + s] = 1'b1;
  end

  fmw_recalc_q #(.N(NOPS)) u_queue (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_i  (pend_set),
    .ack_i  (recalc_ack),
    .pend_o (recalc_pend)
  );
endmodule

// File: rtl/fmw_decoder_chk.sv
module fmw_decoder_chk #(
  parameter int NCH  = 6,
  parameter int NOPS = 24
) (
  input logic            clk,
  input logic            rst_n,
  input logic            wr_valid,
  input logic [7:0]      wr_addr,
  input logic [7:0]      wr_data,
  input logic [1:0]      sp_mode,
  input logic [NOPS-1:0] key_on,
  input logic [NCH*11-1:0] chan_fnum,
  input logic [NCH*3-1:0]  chan_block,
  input logic [NOPS-1:0] recalc_pend,
  input logic [NOPS-1:0] recalc_ack
);
  // R2: the mode field follows the top data bits of a timer-control write
  a_r2_mode_store: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_addr == 8'h27) |=> (sp_mode == $past(wr_data[7:6])));

  // R3: a mode change leaves operators 8 to 10 pending
  a_r3_mode_pends: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_addr == 8'h27 && wr_data[7:6] != sp_mode) |=> (recalc_pend[10:8] == 3'b111));

  // R5: a key write naming a channel beyond the last leaves key levels alone
  a_r5_bad_key: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_addr == 8'h28 && int'(wr_data[2:0]) >= NCH) |=> $stable(key_on));

  // R6: a high-byte write moves no committed frequency or block
  a_r6_latch_only: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_addr == 8'hA4) |=> ($stable(chan_fnum) && $stable(chan_block)));

  // R9: a supplementary commit with the mode at zero queues nothing new
  a_r9_sup_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_addr == 8'hA8 && sp_mode == 2'd0) |=> (recalc_pend == ($past(recalc_pend) & ~$past(recalc_ack))));

  // R11: with no write, every acknowledged bit is clear on the next cycle
  a_r11_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_valid) |=> ((recalc_pend & $past(recalc_ack)) == '0));
endmodule

bind fmw_decoder fmw_decoder_chk #(.NCH(NCH), .NOPS(NOPS)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .wr_valid    (wr_valid),
  .wr_addr     (wr_addr),
  .wr_data     (wr_data),
  .sp_mode     (sp_mode),
  .key_on      (key_on),
  .chan_fnum   (chan_fnum),
  .chan_block  (chan_block),
  .recalc_pend (recalc_pend),
  .recalc_ack  (recalc_ack)
);

// File: tb/fmw_decoder_tb_top.sv
`timescale 1ns/1ps
module fmw_decoder_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_valid = 1'b0;
  logic        wr_ready;
  logic [7:0]  wr_addr = '0;
  logic [2:0]  wr_chan = '0;
  logic [7:0]  wr_data = '0;
  logic [5:0]  tmr_ctrl;
  logic [1:0]  sp_mode;
  logic [23:0] key_on;
  logic [65:0] chan_fnum;
  logic [17:0] chan_block;
  logic [32:0] sup_fnum;
  logic [8:0]  sup_block;
  logic [17:0] alg, fb;
  logic [23:0] recalc_pend;
  logic [23:0] recalc_ack = '0;

  always #10 clk = ~clk;

  fmw_decoder dut_i (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_addr(wr_addr), .wr_chan(wr_chan), .wr_data(wr_data),
    .tmr_ctrl(tmr_ctrl), .sp_mode(sp_mode), .key_on(key_on),
    .chan_fnum(chan_fnum), .chan_block(chan_block),
    .sup_fnum(sup_fnum), .sup_block(sup_block), .alg(alg), .fb(fb),
    .recalc_pend(recalc_pend), .recalc_ack(recalc_ack)
  );

  // behavioural reference state
  int m_tmr, m_mode;
  int m_key[24];
  int m_fn[6], m_bl[6], m_lat[6], m_alg[6], m_fb[6];
  int m_sfn[3], m_sbl[3], m_slat[3];
  logic [23:0] m_pend;

  int vectors = 0, miscompares = 0, cyc = 0;
  bit started = 0;
  string cur_req = "R1";

  task automatic model_reset();
    m_tmr = 0; m_mode = 0; m_pend = '0;
    foreach (m_key[i]) m_key[i] = 0;
    for (int c = 0; c < 6; c++) begin
      m_fn[c] = 0; m_bl[c] = 0; m_lat[c] = 0; m_alg[c] = 0; m_fb[c] = 0;
    end
    for (int s = 0; s < 3; s++) begin
      m_sfn[s] = 0; m_sbl[s] = 0; m_slat[s] = 0;
    end
  endtask

  always @(posedge clk) begin
    logic [23:0] add;
    int d, ch;
    add = '0;
    if (!rst_n) model_reset();
    else begin
      started = 1;
      if (wr_valid) begin
        d = int'(wr_data); ch = int'(wr_chan);
        case (wr_addr)
          8'h27: begin
            if ((d >> 6) != m_mode) add[10:8] = 3'b111;
            m_tmr = d & 63; m_mode = d >> 6;
          end
          8'h28: if ((d & 7) < 6)
            for (int k = 0; k < 4; k++) m_key[(d & 7) * 4 + k] = (d >> (4 + k)) & 1;
          8'hA4: if (ch < 6) m_lat[ch] = d;
          8'hA0: if (ch < 6) begin
            m_bl[ch] = (m_lat[ch] >> 3) & 7;
            m_fn[ch] = ((m_lat[ch] & 7) * 256) + d;
            for (int k = 0; k < 4; k++) add[ch * 4 + k] = 1'b1;
          end
          8'hAC: if (ch < 3) m_slat[ch] = d;
          8'hA8: if (ch < 3) begin
            m_sbl[ch] = (m_slat[ch] >> 3) & 7;
            m_sfn[ch] = ((m_slat[ch] & 7) * 256) + d;
            if (m_mode != 0) add[8 + ch] = 1'b1;
          end
          8'hB0: if (ch < 6) begin
            m_alg[ch] = d & 7; m_fb[ch] = (d >> 3) & 7;
          end
          default: ;
        endcase
      end
      m_pend = (m_pend & ~recalc_ack) | add;
    end
  end

  task automatic chk(string what, longint got, longint exp);
    vectors++;
    if (got != exp) begin
      miscompares++;
      $display("FAIL %s %s: got %0h expected %0h", cur_req, what, got, exp);
    end
  endtask

  always @(negedge clk) if (started) begin
    chk("wr_ready", longint'(wr_ready), 1);
    chk("tmr_ctrl", longint'(tmr_ctrl), m_tmr);
    chk("sp_mode", longint'(sp_mode), m_mode);
    for (int i = 0; i < 24; i++) chk("key_on", longint'(key_on[i]), m_key[i]);
    for (int c = 0; c < 6; c++) begin
      chk("chan_fnum", longint'(chan_fnum[c*11 +: 11]), m_fn[c]);
      chk("chan_block", longint'(chan_block[c*3 +: 3]), m_bl[c]);
      chk("alg", longint'(alg[c*3 +: 3]), m_alg[c]);
      chk("fb", longint'(fb[c*3 +: 3]), m_fb[c]);
    end
    for (int s = 0; s < 3; s++) begin
      chk("sup_fnum", longint'(sup_fnum[s*11 +: 11]), m_sfn[s]);
      chk("sup_block", longint'(sup_block[s*3 +: 3]), m_sbl[s]);
    end
    chk("recalc_pend", longint'(recalc_pend), longint'(m_pend));
  end

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      miscompares++;
      $display("FAIL watchdog: got %0d cycles expected under 150000", cyc);
      summary();
      $finish;
    end
  end

  task automatic wr(logic [7:0] a, logic [2:0] c, logic [7:0] d, logic [23:0] ack = '0);
    @(negedge clk);
    wr_valid = 1'b1; wr_addr = a; wr_chan = c; wr_data = d; recalc_ack = ack;
    @(negedge clk);
    wr_valid = 1'b0; recalc_ack = '0;
  endtask

  task automatic idle(int n, logic [23:0] ack = '0);
    @(negedge clk);
    recalc_ack = ack;
    repeat (n) @(negedge clk);
    recalc_ack = '0;
  endtask

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    cur_req = "R1"; idle(2);
    rst_n = 1'b1;
    idle(2);
    cur_req = "R2"; wr(8'h27, 0, 8'h15);
    cur_req = "R3"; wr(8'h27, 0, 8'h7F);
    wr(8'h27, 0, 8'h40);
    cur_req = "R11"; idle(1, 24'h000700);
    cur_req = "R4"; wr(8'h28, 0, 8'hF0); wr(8'h28, 5, 8'h55); wr(8'h28, 2, 8'hA2);
    wr(8'h28, 0, 8'h30);
    cur_req = "R5"; wr(8'h28, 0, 8'hF6); wr(8'h28, 0, 8'h07);
    cur_req = "R6"; wr(8'hA4, 1, 8'h2B); idle(1);
    cur_req = "R7"; wr(8'hA0, 1, 8'h5C); wr(8'hA0, 1, 8'h01); wr(8'hA4, 5, 8'h3F); wr(8'hA0, 5, 8'hFF);
    cur_req = "R12"; wr(8'hA4, 7, 8'h11); wr(8'hA0, 6, 8'h22); wr(8'h55, 0, 8'hFF);
    @(negedge clk); wr_addr = 8'h27; wr_data = 8'hC3; idle(2);
    cur_req = "R8"; wr(8'hAC, 3, 8'h3A); wr(8'hA8, 3, 8'h77); wr(8'hAC, 2, 8'h1E); wr(8'hA8, 2, 8'h99);
    cur_req = "R9"; wr(8'hA8, 0, 8'h12); wr(8'h27, 0, 8'h00, 24'hFFFFFF);
    idle(1, 24'hFFFFFF); wr(8'hA8, 1, 8'h34);
    cur_req = "R10"; wr(8'hB0, 4, 8'h2D); wr(8'hB0, 0, 8'hFF); wr(8'hB0, 6, 8'h3F);
    cur_req = "R11"; wr(8'hA0, 3, 8'h10, 24'h00F000); idle(1, 24'h00F000);
    for (int n = 0; n < 400; n++) begin
      logic [7:0] addrs[8] = '{8'h27, 8'h28, 8'hA0, 8'hA4, 8'hA8, 8'hAC, 8'hB0, 8'h31};
      cur_req = "R7/R9/R11 mixed";
      wr(addrs[$urandom % 8], 3'($urandom), 8'($urandom), 24'($urandom & $urandom & $urandom));
    end
    idle(3);
    summary();
    $finish;
  end
endmodule